// File: doc/BRIEF.md
# Line-Buffered DMA Channel with Pointer Preset

This block is one DMA channel between a 16-bit device port and a memory that is written and read in whole 64-byte lines. A 32-halfword line store sits between the two sides. A single 5-bit halfword pointer indexes that store. The same pointer serves four purposes: it is the preset position for an unaligned start, the fill position for inbound data, the drain position for outbound data, and the residue count after an inbound stop. Software starts a transfer by giving a byte address, a line count and a direction. The channel clears the low six address bits and then works line by line. After each line it steps the line address by 64 and lowers the count.

For an unaligned inbound start, the CPU pushes halfwords into the line store before the start. Each push advances the pointer by one slot. Device data then lands from the pointer onward, and the first committed line carries the pushed halfwords unchanged. When the device stops partway through a line, that partial line is not written to memory. The pointer holds the number of valid halfwords, the line address holds the destination, and software reads the halfwords back through a peek port.

For an outbound start, the CPU can pop halfwords from the loaded line to skip the head. The rest drains to the device from the pointer onward. The device side ends an outbound transfer by stopping, or the transfer ends when the line count runs out.

Top module: `line_dma_channel`

## Requirements
- R1: After a synchronous reset, busy, done, mem_wr_valid and mem_rd_req are 0, ptr is 0 and line_addr is 0.
- R2: A start with a nonzero line_count makes busy 1 on the next cycle and loads line_addr with base_addr with bits 5:0 cleared. An inbound start (dir_out=0) keeps ptr unchanged. A start with line_count 0 is ignored.
- R3: A cpu_push while idle or filling writes cpu_push_data at slot ptr and increments ptr (modulo 32). While filling, a push takes the cycle and dev_in_ready is 0.
- R4: Inbound, each halfword with dev_in_valid and dev_in_ready is written at slot ptr, and ptr increments. After slot 31 is written, the next cycle shows mem_wr_valid for exactly one cycle with mem_wr_addr = line_addr and ptr = 0. Slot i sits in mem_wr_data bits [16i+15:16i], and pushed slots are unchanged.
- R5: After each line write, line_addr rises by 64. Once line_count lines are written, the channel goes idle with a one-cycle done pulse, and done is only ever high while idle.
- R6: dev_stop during an inbound fill (without completing a line) makes the channel idle on the next cycle with done high and no memory write. ptr then equals the number of valid residue halfwords and line_addr equals their destination. peek_data shows slot peek_idx one cycle after peek_idx is applied.
- R7: An outbound start (dir_out=1) clears ptr and raises mem_rd_req with mem_rd_addr = line_addr until mem_rd_valid. The channel then loads mem_rd_data (same slot layout as R4) and raises dev_out_valid with dev_out_data = slot ptr. Each cycle with dev_out_ready increments ptr.
- R8: During an outbound drain, cpu_pop returns slot ptr on cpu_pop_data one cycle later and increments ptr by exactly one. The device transfer does not happen in that cycle.
- R9: Outbound, when slot 31 leaves the store, line_addr rises by 64 and the next line is requested, or the channel goes idle with done after line_count lines. dev_stop during a drain ends the transfer with ptr at the next unsent slot.
- R10: mem_wr_valid and mem_rd_req are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, taken while idle |
| dir_out | input | 1 | 1 = memory to device, 0 = device to memory |
| base_addr | input | ADDR_W | Transfer byte address |
| line_count | input | CNT_W | Number of 64-byte lines |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when a transfer ends |
| ptr | output | 5 | Halfword pointer / residue count |
| line_addr | output | ADDR_W | Current line address / residue destination |
| cpu_push | input | 1 | CPU writes one halfword at the pointer |
| cpu_push_data | input | HW_W | Halfword to push |
| cpu_pop | input | 1 | CPU reads one halfword at the pointer (outbound) |
| cpu_pop_data | output | HW_W | Popped halfword |
| peek_idx | input | 5 | Slot to read back |
| peek_data | output | HW_W | Contents of slot peek_idx, one cycle later |
| dev_in_valid | input | 1 | Device offers an inbound halfword |
| dev_in_data | input | HW_W | Inbound halfword |
| dev_in_ready | output | 1 | Channel accepts inbound halfword |
| dev_out_valid | output | 1 | Channel offers an outbound halfword |
| dev_out_data | output | HW_W | Outbound halfword |
| dev_out_ready | input | 1 | Device takes the outbound halfword |
| dev_stop | input | 1 | Device ends the transfer |
| mem_wr_valid | output | 1 | Line write strobe |
| mem_wr_addr | output | ADDR_W | Line write address |
| mem_wr_data | output | 32*HW_W | Line write data |
| mem_rd_req | output | 1 | Line read request |
| mem_rd_addr | output | ADDR_W | Line read address |
| mem_rd_valid | input | 1 | Line read data valid |
| mem_rd_data | input | 32*HW_W | Line read data |

## Verification
Inbound runs vary the number of preset pushes: none, a few, and pushes appended to a residue left by an earlier stop. Comparing these shows whether the pointer preset and the untouched head of the first line are both right. Device valid gaps and pushes in the middle of a fill separate correct pointer stepping from double or lost writes. Stops at several points, both before and after a line commit, check that the residue count and destination are right and that no spurious line is written. Outbound runs mix head pops with random device readiness and stops, which tells pop priority, drain order and the line-to-line address step apart.

// File: rtl/line_dma_pkg.sv
package line_dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_COMMIT,
    ST_FETCH,
    ST_DRAIN
  } dma_state_t;
endpackage

// File: rtl/line_dma_store.sv
module line_dma_store #(
  parameter int HW_W    = 16,
  parameter int LINE_HW = 32,
  localparam int IDX_W  = $clog2(LINE_HW),
  localparam int LINE_W = HW_W * LINE_HW
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [HW_W-1:0]   wr_data,
  input  logic              ld_en,
  input  logic [LINE_W-1:0] ld_line,
  output logic [LINE_W-1:0] line_q
);
  // One register per halfword slot: a whole line is loaded or presented in one cycle.
  for (genvar g = 0; g < LINE_HW; g++) begin : g_slot
    logic [HW_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (ld_en)
        slot_q <= ld_line[g*HW_W +: HW_W];
      else if (wr_en && (wr_idx == IDX_W'(g)))
        slot_q <= wr_data;
    end
    assign line_q[g*HW_W +: HW_W] = slot_q;
  end
endmodule

// File: rtl/line_dma_seq.sv
module line_dma_seq
  import line_dma_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 16,
  parameter int HW_W    = 16,
  parameter int LINE_HW = 32,
  localparam int PTR_W  = $clog2(LINE_HW)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              dir_out,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [CNT_W-1:0]  line_count,
  input  logic              cpu_push,
  input  logic [HW_W-1:0]   cpu_push_data,
  input  logic              cpu_pop,
  input  logic              dev_in_valid,
  input  logic [HW_W-1:0]   dev_in_data,
  input  logic              dev_out_ready,
  input  logic              dev_stop,
  input  logic              mem_rd_valid,
  output dma_state_t        state_o,
  output logic [PTR_W-1:0]  ptr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o,
  output logic              wr_en,
  output logic [PTR_W-1:0]  wr_idx,
  output logic [HW_W-1:0]   wr_data,
  output logic              ld_en
);
  localparam int LINE_BYTES           = LINE_HW * HW_W / 8;
  localparam logic [PTR_W-1:0]  LAST  = PTR_W'(LINE_HW - 1);
  localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(LINE_BYTES);
  localparam logic [ADDR_W-1:0] OFSM  = ADDR_W'(LINE_BYTES - 1);

  dma_state_t        st;
  logic [PTR_W-1:0]  ptr;
  logic [ADDR_W-1:0] addr;
  logic [CNT_W-1:0]  left;
  logic              stop_q;
  logic              done_q;

  logic go, push_ok, dev_acc, fill_wr, drain_adv, last_left;

  always_comb begin
    go        = start && (line_count != '0);
    push_ok   = cpu_push && ((st == ST_IDLE && !go) || st == ST_FILL);
    dev_acc   = (st == ST_FILL) && dev_in_valid && !cpu_push;
    fill_wr   = push_ok || dev_acc;
    drain_adv = (st == ST_DRAIN) && (cpu_pop || dev_out_ready);
    last_left = (left == CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      ptr    <= '0;
      addr   <= '0;
      left   <= '0;
      stop_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (go) begin
            addr   <= base_addr & ~OFSM;
            left   <= line_count;
            stop_q <= 1'b0;
            if (dir_out) begin
              ptr <= '0;
              st  <= ST_FETCH;
            end else begin
              st  <= ST_FILL;
            end
          end else if (push_ok) begin
            ptr <= ptr + 1'b1;
          end
        end
        ST_FILL: begin
          if (fill_wr) ptr <= ptr + 1'b1;
          if (fill_wr && ptr == LAST) begin
            st     <= ST_COMMIT;
            stop_q <= dev_stop;
          end else if (dev_stop) begin
            st     <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
        ST_COMMIT: begin
          addr <= addr + STEP;
          left <= left - 1'b1;
          if (last_left || stop_q || dev_stop) begin
            st     <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            st <= ST_FILL;
          end
        end
        ST_FETCH: begin
          if (dev_stop) begin
            st     <= ST_IDLE;
            done_q <= 1'b1;
          end else if (mem_rd_valid) begin
            st <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (drain_adv) ptr <= ptr + 1'b1;
          if (drain_adv && ptr == LAST) begin
            addr <= addr + STEP;
            left <= left - 1'b1;
            if (last_left || dev_stop) begin
              st     <= ST_IDLE;
              done_q <= 1'b1;
            end else begin
              st <= ST_FETCH;
            end
          end else if (dev_stop) begin
            st     <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign state_o = st;
  assign ptr_o   = ptr;
  assign addr_o  = addr;
  assign done_o  = done_q;
  assign wr_en   = fill_wr;
  assign wr_idx  = ptr;
  assign wr_data = cpu_push ? cpu_push_data : dev_in_data;
  assign ld_en   = (st == ST_FETCH) && mem_rd_valid && !dev_stop;
endmodule

// File: rtl/line_dma_channel.sv
module line_dma_channel
  import line_dma_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 16,
  parameter int HW_W    = 16,
  parameter int LINE_HW = 32,
  localparam int PTR_W  = $clog2(LINE_HW),
  localparam int LINE_W = HW_W * LINE_HW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              dir_out,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [CNT_W-1:0]  line_count,
  output logic              busy,
  output logic              done,
  output logic [PTR_W-1:0]  ptr,
  output logic [ADDR_W-1:0] line_addr,
  input  logic              cpu_push,
  input  logic [HW_W-1:0]   cpu_push_data,
  input  logic              cpu_pop,
  output logic [HW_W-1:0]   cpu_pop_data,
  input  logic [PTR_W-1:0]  peek_idx,
  output logic [HW_W-1:0]   peek_data,
  input  logic              dev_in_valid,
  input  logic [HW_W-1:0]   dev_in_data,
  output logic              dev_in_ready,
  output logic              dev_out_valid,
  output logic [HW_W-1:0]   dev_out_data,
  input  logic              dev_out_ready,
  input  logic              dev_stop,
  output logic              mem_wr_valid,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [LINE_W-1:0] mem_wr_data,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [LINE_W-1:0] mem_rd_data
);
  dma_state_t        st;
  logic              wr_en, ld_en;
  logic [PTR_W-1:0]  wr_idx;
  logic [HW_W-1:0]   wr_data;
  logic [LINE_W-1:0] line_q;

  line_dma_seq #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .HW_W(HW_W), .LINE_HW(LINE_HW)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .dir_out(dir_out),
    .base_addr(base_addr), .line_count(line_count),
    .cpu_push(cpu_push), .cpu_push_data(cpu_push_data), .cpu_pop(cpu_pop),
    .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data),
    .dev_out_ready(dev_out_ready), .dev_stop(dev_stop),
    .mem_rd_valid(mem_rd_valid),
    .state_o(st), .ptr_o(ptr), .addr_o(line_addr), .done_o(done),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .ld_en(ld_en)
  );

  line_dma_store #(.HW_W(HW_W), .LINE_HW(LINE_HW)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .ld_en(ld_en), .ld_line(mem_rd_data), .line_q(line_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_pop_data <= '0;
      peek_data    <= '0;
    end else begin
      if (st == ST_DRAIN && cpu_pop)
        cpu_pop_data <= line_q[int'(ptr)*HW_W +: HW_W];
      peek_data <= line_q[int'(peek_idx)*HW_W +: HW_W];
    end
  end

  assign busy          = (st != ST_IDLE);
  assign dev_in_ready  = (st == ST_FILL) && !cpu_push;
  assign dev_out_valid = (st == ST_DRAIN);
  assign dev_out_data  = line_q[int'(ptr)*HW_W +: HW_W];
  assign mem_wr_valid  = (st == ST_COMMIT);
  assign mem_wr_addr   = line_addr;
  assign mem_wr_data   = line_q;
  assign mem_rd_req    = (st == ST_FETCH);
  assign mem_rd_addr   = line_addr;
endmodule

// File: rtl/line_dma_chk.sv
module line_dma_chk #(
  parameter int ADDR_W  = 32,
  parameter int HW_W    = 16,
  parameter int LINE_HW = 32,
  localparam int PTR_W  = $clog2(LINE_HW),
  localparam int LINE_BYTES = LINE_HW * HW_W / 8,
  localparam int OFS_W  = $clog2(LINE_BYTES)
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [PTR_W-1:0]  ptr,
  input logic [ADDR_W-1:0] line_addr,
  input logic              cpu_push,
  input logic              cpu_pop,
  input logic              dev_out_valid,
  input logic              mem_wr_valid,
  input logic              mem_rd_req
);
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!busy && ptr == '0 && !done));

  p_line_aligned_r2: assert property (@(posedge clk) disable iff (rst)
    line_addr[OFS_W-1:0] == '0);

  p_push_step_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy && cpu_push && !start) |=> ptr == $past(ptr) + 1'b1);

  p_wr_ptr_zero_r4: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid |-> ptr == '0);

  p_wr_single_r4: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid |=> !mem_wr_valid);

  p_addr_step_r5: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid |=> line_addr == $past(line_addr) + ADDR_W'(LINE_BYTES));

  p_done_idle_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_pop_one_r8: assert property (@(posedge clk) disable iff (rst)
    (cpu_pop && dev_out_valid) |=> ptr == $past(ptr) + 1'b1);

  p_no_mix_r10: assert property (@(posedge clk) disable iff (rst)
    !(mem_wr_valid && mem_rd_req));
endmodule

bind line_dma_channel line_dma_chk #(
  .ADDR_W(ADDR_W), .HW_W(HW_W), .LINE_HW(LINE_HW)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .ptr(ptr), .line_addr(line_addr), .cpu_push(cpu_push), .cpu_pop(cpu_pop),
  .dev_out_valid(dev_out_valid), .mem_wr_valid(mem_wr_valid),
  .mem_rd_req(mem_rd_req)
);

// File: tb/line_dma_channel_tb_top.sv
module line_dma_channel_tb_top;
  localparam int AW = 32, CW = 16, HW = 16, LHW = 32, PW = 5, LW = HW * LHW;

  logic clk = 1'b0;
  logic rst, start, dir_out, cpu_push, cpu_pop, dev_in_valid, dev_out_ready;
  logic dev_stop, mem_rd_valid;
  logic [AW-1:0] base_addr;
  logic [CW-1:0] line_count;
  logic [HW-1:0] cpu_push_data, dev_in_data;
  logic [PW-1:0] peek_idx;
  logic [LW-1:0] mem_rd_data;
  logic busy, done, dev_in_ready, dev_out_valid, mem_wr_valid, mem_rd_req;
  logic [PW-1:0] ptr;
  logic [AW-1:0] line_addr, mem_wr_addr, mem_rd_addr;
  logic [HW-1:0] cpu_pop_data, peek_data, dev_out_data;
  logic [LW-1:0] mem_wr_data;

  line_dma_channel dut_i (.*);

  always #5 clk = ~clk;

  int checks = 0, failures = 0;
  logic [HW-1:0] g_line [LHW];
  int g_ptr = 0;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] align(input logic [AW-1:0] a);
    return a & ~32'h3f;
  endfunction

  function automatic logic [HW-1:0] src_hw(input logic [AW-1:0] a, input int i);
    return (a[21:6] * 16'h003b + 16'(i) * 16'h0101) ^ 16'h5a3c;
  endfunction

  function automatic logic [LW-1:0] src_line(input logic [AW-1:0] a);
    logic [LW-1:0] v;
    for (int i = 0; i < LHW; i++) v[i*HW +: HW] = src_hw(a, i);
    return v;
  endfunction

  function automatic logic [LW-1:0] model_line();
    logic [LW-1:0] v;
    for (int i = 0; i < LHW; i++) v[i*HW +: HW] = g_line[i];
    return v;
  endfunction

  task automatic store(input logic [HW-1:0] d);
    g_line[g_ptr] = d;
    g_ptr = (g_ptr + 1) % LHW;
  endtask

  task automatic in_run(input logic [AW-1:0] base, input int cnt, input int npush,
                        input int stop_after, input bit mix);
    logic [AW-1:0] eaddr;
    logic [HW-1:0] d;
    int acc, nwr;
    bit stopped, fin, v;
    for (int k = 0; k < npush; k++) begin
      d = 16'($urandom);
      cpu_push = 1'b1; cpu_push_data = d;
      step();
      cpu_push = 1'b0;
      store(d);
      chk("R3 preset push ptr", LW'(ptr), LW'(g_ptr));
    end
    start = 1'b1; dir_out = 1'b0; base_addr = base; line_count = CW'(cnt);
    step();
    start = 1'b0;
    eaddr = align(base);
    chk("R2 busy after start", LW'(busy), LW'(1));
    chk("R2 aligned line_addr", LW'(line_addr), LW'(eaddr));
    chk("R2 inbound keeps ptr", LW'(ptr), LW'(g_ptr));
    acc = 0; nwr = 0; stopped = 0; fin = 0;
    for (int guard = 0; guard < 6000; guard++) begin
      if (!busy) begin
        chk("R5 done pulse at end", LW'(done), LW'(1));
        fin = 1;
        break;
      end
      if (mem_wr_valid) begin
        chk("R4 line write addr", LW'(mem_wr_addr), LW'(eaddr));
        chk("R4 line write data", mem_wr_data, model_line());
        chk("R4 ptr wraps", LW'(ptr), LW'(0));
        eaddr += 32'd64; nwr++;
        step();
        chk("R5 line_addr step", LW'(line_addr), LW'(eaddr));
        continue;
      end
      if (stop_after >= 0 && acc == stop_after) begin
        dev_stop = 1'b1;
        step();
        dev_stop = 1'b0;
        stopped = 1; fin = 1;
        chk("R6 idle after stop", LW'(busy), LW'(0));
        chk("R6 done after stop", LW'(done), LW'(1));
        chk("R6 residue count", LW'(ptr), LW'(g_ptr));
        chk("R6 residue address", LW'(line_addr), LW'(eaddr));
        break;
      end
      d = 16'($urandom);
      if (mix && ($urandom % 6 == 0)) begin
        cpu_push = 1'b1; cpu_push_data = d;
        dev_in_valid = 1'b1; dev_in_data = ~d;
        #1;
        chk("R3 push blocks device", LW'(dev_in_ready), LW'(0));
        step();
        cpu_push = 1'b0; dev_in_valid = 1'b0;
        store(d);
      end else begin
        v = ($urandom % 3 != 0);
        dev_in_valid = v; dev_in_data = d;
        step();
        dev_in_valid = 1'b0;
        if (v) begin
          store(d);
          acc++;
        end
      end
    end
    if (!fin) chk("R5 inbound run finished", 0, 1);
    if (!stopped) begin
      chk("R5 lines written", LW'(nwr), LW'(cnt));
      chk("R5 ptr zero at end", LW'(ptr), LW'(0));
    end
    for (int i = 0; i < (stopped ? g_ptr : 0); i++) begin
      peek_idx = PW'(i);
      step();
      chk("R6 residue readback", LW'(peek_data), LW'(g_line[i]));
    end
  endtask

  task automatic out_run(input logic [AW-1:0] base, input int cnt, input int npop,
                         input int stop_after);
    logic [AW-1:0] eaddr;
    int left, xfer, pops;
    bit fin, r;
    start = 1'b1; dir_out = 1'b1; base_addr = base; line_count = CW'(cnt);
    step();
    start = 1'b0;
    eaddr = align(base); left = cnt; g_ptr = 0; xfer = 0; pops = npop; fin = 0;
    chk("R7 outbound clears ptr", LW'(ptr), LW'(0));
    chk("R2 aligned line_addr out", LW'(line_addr), LW'(eaddr));
    for (int guard = 0; guard < 8000; guard++) begin
      if (!busy) begin
        chk("R9 done pulse at end", LW'(done), LW'(1));
        fin = 1;
        break;
      end
      if (mem_rd_req) begin
        chk("R7 read addr", LW'(mem_rd_addr), LW'(eaddr));
        chk("R7 no drain while fetching", LW'(dev_out_valid), LW'(0));
        chk("R10 no write with read", LW'(mem_wr_valid), LW'(0));
        repeat ($urandom % 3) step();
        mem_rd_valid = 1'b1; mem_rd_data = src_line(eaddr);
        step();
        mem_rd_valid = 1'b0;
        for (int i = 0; i < LHW; i++) g_line[i] = src_hw(eaddr, i);
        continue;
      end
      chk("R7 drain data", LW'(dev_out_data), LW'(src_hw(eaddr, g_ptr)));
      chk("R7 drain ptr", LW'(ptr), LW'(g_ptr));
      if (stop_after >= 0 && xfer == stop_after) begin
        dev_stop = 1'b1;
        step();
        dev_stop = 1'b0;
        fin = 1;
        chk("R9 idle after stop", LW'(busy), LW'(0));
        chk("R9 ptr after stop", LW'(ptr), LW'(g_ptr));
        chk("R9 addr after stop", LW'(line_addr), LW'(eaddr));
        break;
      end
      if (pops > 0) begin
        cpu_pop = 1'b1; dev_out_ready = 1'b1;
        step();
        cpu_pop = 1'b0; dev_out_ready = 1'b0;
        chk("R8 pop data", LW'(cpu_pop_data), LW'(src_hw(eaddr, g_ptr)));
        r = 1'b1;
        pops--;
      end else begin
        r = ($urandom % 4 != 0);
        dev_out_ready = r;
        step();
        dev_out_ready = 1'b0;
        if (r) xfer++;
      end
      if (r) begin
        g_ptr++;
        if (g_ptr == LHW) begin
          g_ptr = 0; eaddr += 32'd64; left--;
          chk("R9 line step", LW'(line_addr), LW'(eaddr));
        end
        chk("R8 ptr single step", LW'(ptr), LW'(g_ptr));
      end
    end
    if (!fin) chk("R9 outbound run finished", 0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R1..all act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    rst = 1'b1; start = 0; dir_out = 0; cpu_push = 0; cpu_pop = 0;
    dev_in_valid = 0; dev_out_ready = 0; dev_stop = 0; mem_rd_valid = 0;
    base_addr = '0; line_count = '0; cpu_push_data = '0; dev_in_data = '0;
    peek_idx = '0; mem_rd_data = '0;
    repeat (3) step();
    chk("R1 busy", LW'(busy), LW'(0));
    chk("R1 ptr", LW'(ptr), LW'(0));
    chk("R1 line_addr", LW'(line_addr), LW'(0));
    chk("R1 write/read idle", LW'({mem_wr_valid, mem_rd_req, done}), LW'(0));
    rst = 1'b0;
    step();

    // R2: zero-count start is ignored
    start = 1'b1; dir_out = 1'b0; base_addr = 32'h0000_1000; line_count = '0;
    step();
    start = 1'b0;
    chk("R2 zero count ignored", LW'(busy), LW'(0));

    in_run(32'h1000_0046, 2, 3, -1, 0);   // preset of 3, two full lines
    in_run(32'h2000_0000, 1, 0, -1, 1);   // mid-fill pushes
    in_run(32'h3000_0010, 4, 8, 40, 0);   // stop in second line, residue 16
    in_run(32'h3100_0000, 3, 0, 5, 0);    // residue appended, stop again
    out_run(32'h4000_0084, 2, 5, -1);     // head pops then drain
    out_run(32'h5000_0000, 3, 0, 40);     // outbound stop

    for (int it = 0; it < 10; it++) begin
      int cnt, n, total;
      logic [AW-1:0] b;
      cnt = 1 + ($urandom % 3);
      b = $urandom;
      if ($urandom % 2 == 0) begin
        n = $urandom % (LHW - g_ptr);
        total = cnt * LHW - g_ptr - n;
        in_run(b, cnt, n, ($urandom % 2 == 0) ? int'($urandom % total) : -1, 1'($urandom % 2));
      end else begin
        n = $urandom % 4;
        total = cnt * LHW - n;
        out_run(b, cnt, n, ($urandom % 2 == 0) ? int'($urandom % total) : -1);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule